// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the protocol side of a byte-addressed serial memory that sits on a two-wire bus as a target. It runs on a fast system clock and oversamples the bus clock and data lines. It finds bus start and stop events and takes in a device header followed by two address bytes. It acknowledges by pulling the data line low through an open-drain style output enable. The block handles single-byte writes, page writes, reads from the current address, reads from a loaded address, and sequential reads.

The storage array lives outside the block and is reached through a plain memory port with a combinational read. The block does not write incoming bytes straight to the array. It collects them in a one-page buffer and commits them only after the master sends a stop. The commit opens a timed busy window. While that window is open, the block does not acknowledge its own header, so a master can poll until the write is done.

Top module: `twi_mem_target`

## Requirements
- R1: A falling data edge while the bus clock is high is a start, and a rising data edge while the bus clock is high is a stop. A start at any point drops the transfer in progress and restarts header reception. Page data not yet followed by a stop is discarded and never written.
- R2: The header byte is taken most significant bit first. It is the type code 1010, then three select bits that must equal `chip_sel_i`, then a direction bit in which 1 means read. On a match the block pulls the data line low during the ninth clock.
- R3: A header with the wrong type code or wrong select bits gets no acknowledge. Every following byte is then ignored, with no acknowledge and no array access, until the next start.
- R4: A write header is followed by a high and a low address byte, and the block acknowledges each one. The pointer is 14 bits wide: the low byte and the low six bits of the high byte. The top two bits of the high byte have no effect.
- R5: After a write header and the address bytes, each data byte is acknowledged. The bytes reach the array only after the stop, through a write strobe. A single data byte produces exactly one array write.
- R6: During a write, only the low six pointer bits advance after each data byte, so the data wraps inside the 64-byte page. The array writes from one commit all land in that page, and no other page changes.
- R7: A read header with no address phase returns data from the pointer. The pointer holds the address one past the last byte read, or the page-wrapped address one past the last byte written.
- R8: A write header, the address bytes, a repeated start and then a read header return data from the loaded address.
- R9: In a read, the bits change only after falling bus clock edges. A master acknowledge (data low in the ninth clock) makes the next byte follow, and the pointer wraps from 0x3FFF to 0x0000. A missing acknowledge ends the read, and the data line is released.
- R10: After a stop that ends a write with at least one data byte, the block runs a busy window of `WR_CYCLES` clocks. During that window it does not acknowledge its header and does not drive the data line. After the window it acknowledges again.
- R11: The data output enable changes only while the bus clock is low. Input bits are taken on rising bus clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired bus value) |
| chip_sel_i | input | 3 | Hardwired select value matched against the header |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| mem_addr_o | output | ADDR_W | Array address: read pointer, or commit address while busy |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, combinational from mem_addr_o |

## Verification
The hardest case to reach is a write that wraps inside a page. The pointer has to start near the end of a page, and the data must run past the page boundary. The whole page is then read back in one sequential read and compared byte by byte against values computed from the page offset. Unwritten bytes must still show their background pattern. The busy window is reached by polling with headers straight after the stop. The first poll must go unacknowledged and a later poll must be acknowledged. Header matching is swept over all 64 select and header pairs.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s      = scl_ff[SYNC_N-1];
  assign sda_o      = sda_ff[SYNC_N-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int PAGE_W = 6,
  localparam int PAGE = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [7:0]        wdata_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  logic [7:0]      slot_q [PAGE];
  logic [PAGE-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q[widx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) slot_q[widx_i] <= wdata_i;
  end

  assign rdata_o  = slot_q[ridx_i];
  assign rvalid_o = mask_q[ridx_i];
  assign any_o    = |mask_q;
endmodule

// File: rtl/twi_commit_seq.sv
module twi_commit_seq #(
  parameter int ADDR_W    = 14,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 2000,
  localparam int PG_W  = ADDR_W - PAGE_W,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic              slot_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              we_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic [PG_W-1:0]   page_o
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] NSLOT = CNT_W'(1 << PAGE_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      page_o <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
        page_o <= page_i;
      end
    end else if (cnt_q == LAST) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = busy_o && (cnt_q == LAST);
  assign idx_o  = cnt_q[PAGE_W-1:0];
  // slots are drained one per clock at the front of the window
  assign we_o   = busy_o && (cnt_q < NSLOT) && slot_valid_i;
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 2000,
  localparam int HI_W = ADDR_W - 8,
  localparam int PG_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic sda_s, rise, fall, start, stop;
  logic busy_w, done_w, slot_valid, any_w, buf_wr, commit_go, dev_hit, ack_slot;
  logic [PAGE_W-1:0] cidx;
  logic [PG_W-1:0]   cpage;
  logic [7:0]        slot_data;

  phase_e            phase_q;
  logic [3:0]        bit_cnt_q;
  logic              in_ack_q, rw_q, m_ack_q, oe_q;
  logic [7:0]        sh_q, tx_q;
  logic [HI_W-1:0]   ahi_q;
  logic [ADDR_W-1:0] ptr_q;

  twi_line_sync #(.SYNC_N(2)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  assign ack_slot  = (phase_q != PH_IDLE) && !start && !stop && fall && !in_ack_q
                     && (bit_cnt_q == 4'd8);
  assign buf_wr    = ack_slot && (phase_q == PH_WDAT);
  assign commit_go = stop && (phase_q == PH_WDAT) && any_w;
  assign dev_hit   = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == chip_sel_i) && !busy_w;

  twi_page_buf #(.PAGE_W(PAGE_W)) buf_i (
    .clk_i, .rst_ni,
    .wr_i(buf_wr), .widx_i(ptr_q[PAGE_W-1:0]), .wdata_i(sh_q),
    .clr_i((start && !busy_w) || done_w),
    .ridx_i(cidx), .rdata_o(slot_data), .rvalid_o(slot_valid), .any_o(any_w)
  );

  twi_commit_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) seq_i (
    .clk_i, .rst_ni,
    .go_i(commit_go), .page_i(ptr_q[ADDR_W-1:PAGE_W]), .slot_valid_i(slot_valid),
    .busy_o(busy_w), .done_o(done_w), .we_o(mem_we_o), .idx_o(cidx), .page_o(cpage)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      rw_q      <= 1'b0;
      m_ack_q   <= 1'b0;
      oe_q      <= 1'b0;
      sh_q      <= '0;
      tx_q      <= '0;
      ahi_q     <= '0;
      ptr_q     <= '0;
    end else if (start) begin
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop) begin
      phase_q  <= PH_IDLE;
      in_ack_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (rise) begin
        if (in_ack_q) m_ack_q <= ~sda_s;
        else begin
          sh_q      <= {sh_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
      end else if (fall) begin
        if (in_ack_q) begin
          // end of ninth clock: release and move on
          in_ack_q  <= 1'b0;
          bit_cnt_q <= '0;
          oe_q      <= 1'b0;
          unique case (phase_q)
            PH_DEV: begin
              if (rw_q) begin
                phase_q <= PH_RDAT;
                tx_q    <= mem_rdata_i;
                oe_q    <= ~mem_rdata_i[7];
                ptr_q   <= ptr_q + ADDR_W'(1);
              end else phase_q <= PH_AHI;
            end
            PH_AHI: phase_q <= PH_ALO;
            PH_ALO: phase_q <= PH_WDAT;
            PH_RDAT: begin
              if (m_ack_q) begin
                tx_q  <= mem_rdata_i;
                oe_q  <= ~mem_rdata_i[7];
                ptr_q <= ptr_q + ADDR_W'(1);
              end else phase_q <= PH_IDLE;
            end
            default: ;
          endcase
        end else if (bit_cnt_q == 4'd8) begin
          in_ack_q <= 1'b1;
          unique case (phase_q)
            PH_DEV: begin
              if (dev_hit) begin
                oe_q <= 1'b1;
                rw_q <= sh_q[0];
              end else begin
                phase_q  <= PH_IDLE;
                in_ack_q <= 1'b0;
              end
            end
            PH_AHI: begin
              ahi_q <= sh_q[HI_W-1:0];
              oe_q  <= 1'b1;
            end
            PH_ALO: begin
              ptr_q <= {ahi_q, sh_q};
              oe_q  <= 1'b1;
            end
            PH_WDAT: begin
              ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
              oe_q <= 1'b1;
            end
            PH_RDAT: oe_q <= 1'b0;
            default: ;
          endcase
        end else if (phase_q == PH_RDAT && bit_cnt_q != 4'd0) begin
          tx_q <= {tx_q[6:0], 1'b0};
          oe_q <= ~tx_q[6];
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = busy_w ? {cpage, cidx} : ptr_q;
  assign mem_wdata_o = slot_data;
endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_i
);
  logic [2:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd4 && scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3))
    |-> $stable(sda_oe_o)); // R11

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_o); // R10

  AST_WE_WITHIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_i); // R5

  AST_WE_SAME_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd1 && mem_we_o && $past(mem_we_o))
    |-> (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W]))); // R6
endmodule

bind twi_mem_target twi_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .busy_i(busy_w)
);

// File: tb/twi_mem_target_tb_top.sv
module twi_mem_target_tb_top;
  localparam int Q   = 8;
  localparam int WRC = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] chip_sel = 3'b101;
  logic sda_oe, mem_we, sda_bus;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, glitch = 0, we_cnt = 0;
  bit finished = 1'b0;

  logic [13:0] w_addr [32];
  logic [7:0]  w_data [32];
  int w_n = 0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  twi_mem_target #(.ADDR_W(14), .PAGE_W(6), .WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .chip_sel_i(chip_sel), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'(a >> 6) ^ 8'h5C;
  endfunction

  always_comb begin
    mem_rdata = pat(int'(mem_addr));
    for (int i = 0; i < 32; i++)
      if (i < w_n && w_addr[i] == mem_addr) mem_rdata = w_data[i];
  end

  always @(posedge clk) begin
    if (mem_we && w_n < 32) begin
      w_addr[w_n] <= mem_addr;
      w_data[w_n] <= mem_wdata;
      w_n         <= w_n + 1;
      we_cnt      <= we_cnt + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_sda = 1'b1; tk(Q); m_scl = 1'b1; tk(Q); m_sda = 1'b0; tk(Q); m_scl = 1'b0; tk(Q);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; tk(Q); m_scl = 1'b1; tk(Q); m_sda = 1'b1; tk(2 * Q);
  endtask

  task automatic bit_out(logic b);
    m_sda = b; tk(Q); m_scl = 1'b1; tk(2 * Q); m_scl = 1'b0; tk(Q);
  endtask

  task automatic bit_in(output logic b);
    logic early;
    m_sda = 1'b1; tk(Q); m_scl = 1'b1; tk(2);
    early = sda_bus; tk(Q - 2);
    b = sda_bus; tk(Q - 1);
    if (sda_bus != b || early != b) glitch++;
    tk(1); m_scl = 1'b0; tk(Q);
  endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~mack);
  endtask

  function automatic logic [7:0] hdr(logic rd);
    return {4'b1010, 3'b101, rd};
  endfunction

  // write header + address bytes, repeated start, read header
  task automatic read_at(logic [7:0] hi, logic [7:0] lo, string req);
    logic a;
    b_start();
    send_byte(hdr(1'b0), a); chk({req, " hdr ack"}, a, 1);
    send_byte(hi, a);        chk({req, " hi ack"}, a, 1);
    send_byte(lo, a);        chk({req, " lo ack"}, a, 1);
    b_start();
    send_byte(hdr(1'b1), a); chk({req, " rd hdr ack"}, a, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int base_we, exp_v;

    tk(4); rst_n = 1'b1; tk(4);
    chk("reset oe", sda_oe, 0);
    chk("reset we", mem_we, 0);

    // R2 R3: sweep select value against header select bits
    for (int c = 0; c < 8; c++) begin
      for (int h = 0; h < 8; h++) begin
        chip_sel = 3'(c);
        b_start();
        send_byte({4'b1010, 3'(h), 1'b0}, a);
        chk((h == c) ? "R2 match ack" : "R3 mismatch nack", a, (h == c) ? 1 : 0);
        b_stop();
      end
    end
    chip_sel = 3'b101;
    b_start(); send_byte({4'b1011, 3'b101, 1'b0}, a); chk("R2 type code", a, 0); b_stop();

    // R3: bytes after a mismatched header are ignored
    base_we = we_cnt;
    b_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a); chk("R3 hdr nack", a, 0);
    send_byte(8'h00, a); chk("R3 ignored hi", a, 0);
    send_byte(8'h40, a); chk("R3 ignored lo", a, 0);
    send_byte(8'h99, a); chk("R3 ignored data", a, 0);
    b_stop(); tk(WRC + 20);
    chk("R3 no array write", we_cnt - base_we, 0);

    // R4 R5 R10: byte write with don't-care upper address bits
    base_we = we_cnt;
    b_start();
    send_byte(hdr(1'b0), a); chk("R4 hdr", a, 1);
    send_byte(8'hC1, a);     chk("R4 hi ack", a, 1);
    send_byte(8'h23, a);     chk("R4 lo ack", a, 1);
    send_byte(8'h5A, a);     chk("R5 data ack", a, 1);
    chk("R5 no write before stop", we_cnt - base_we, 0);
    b_stop();
    b_start(); send_byte(hdr(1'b0), a); chk("R10 first poll nack", a, 0); b_stop();
    tk(WRC + 20);
    chk("R5 single write", we_cnt - base_we, 1);
    read_at(8'h01, 8'h23, "R8");
    recv_byte(1'b0, d); b_stop();
    chk("R4 R8 read loaded address", d, 8'h5A);

    // R7: current address read continues after last byte read
    b_start(); send_byte(hdr(1'b1), a); chk("R7 rd hdr", a, 1);
    recv_byte(1'b0, d); b_stop();
    chk("R7 current address", d, pat(14'h0124));

    // R6 R10: page write wrapping inside page 5 from offset 60
    base_we = we_cnt;
    b_start();
    send_byte(hdr(1'b0), a);
    send_byte(8'h01, a);
    send_byte(8'h7C, a);
    for (int i = 0; i < 8; i++) begin
      send_byte(8'(8'h30 + i), a); chk("R6 data ack", a, 1);
    end
    b_stop();
    begin
      int polls = 0;
      bit got = 1'b0;
      for (int p = 0; p < 6 && !got; p++) begin
        b_start(); send_byte(hdr(1'b0), a); b_stop();
        polls++;
        if (a) got = 1'b1;
      end
      chk("R10 ack after window", got, 1);
      chk("R10 not at once", (polls > 1) ? 1 : 0, 1);
    end
    chk("R6 write count", we_cnt - base_we, 8);
    read_at(8'h01, 8'h40, "R6");
    for (int o = 0; o < 64; o++) begin
      recv_byte(o != 63, d);
      if (o >= 60)     exp_v = 8'h30 + (o - 60);
      else if (o < 4)  exp_v = 8'h34 + o;
      else             exp_v = pat(14'h0140 + o);
      chk("R6 page content", d, exp_v);
    end
    b_stop();
    read_at(8'h01, 8'h80, "R6");
    recv_byte(1'b0, d); b_stop();
    chk("R6 next page untouched", d, pat(14'h0180));

    // R9: sequential read wraps at top of array, nack ends it
    read_at(8'h3F, 8'hFE, "R9");
    recv_byte(1'b1, d); chk("R9 3FFE", d, pat(14'h3FFE));
    recv_byte(1'b1, d); chk("R9 3FFF", d, pat(14'h3FFF));
    recv_byte(1'b1, d); chk("R9 wrap 0000", d, pat(0));
    recv_byte(1'b0, d); chk("R9 0001", d, pat(1));
    tk(2);
    chk("R9 released after nack", sda_oe, 0);
    b_stop();

    // R1: repeated start aborts a write, no commit and no busy
    base_we = we_cnt;
    b_start();
    send_byte(hdr(1'b0), a);
    send_byte(8'h02, a);
    send_byte(8'h00, a);
    send_byte(8'hEE, a);
    send_byte(8'hEF, a);
    b_start();
    b_stop();
    b_start(); send_byte(hdr(1'b0), a); chk("R1 no busy after abort", a, 1); b_stop();
    tk(WRC + 20);
    chk("R1 aborted data not written", we_cnt - base_we, 0);
    read_at(8'h02, 8'h00, "R1");
    recv_byte(1'b0, d); b_stop();
    chk("R1 array unchanged", d, pat(14'h0200));

    chk("R11 data stable while clock high", glitch, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule